// File: doc/BRIEF.md
# Vectored Priority Interrupt Controller

This block collects up to 32 level-sensitive interrupt request lines and drives a single interrupt line to a processor. Each source carries a programmable urgency level and a programmable handler address, and both are held in a small memory-mapped register bank. When several enabled sources are pending, the controller selects one. The lowest level value wins. Among sources at that same level, the lowest source number wins.

Software services an interrupt in three steps. It reads the vector register, which returns the handler address of the winner and marks that source as being serviced. It runs the handler. It then writes any value to the vector register to end service. A stack of active levels supports nesting: while a handler runs, only a source that is strictly more urgent than the level on top of the stack can raise the interrupt line again. Ending service pops the stack and restores the previous threshold.

Top module: `prio_vector_irq_ctrl`

## Requirements
- R1: After reset, every priority field reads 15 (0xF), the enable mask reads 0, the vector register reads 0 and irq_o is low.
- R2: The priority register of source n is at 0x200 + 4n. It holds the value written to bits 3:0. Bits 31:4 read as zero and ignore written data.
- R3: A write to 0x010 sets the enable bits that are 1 in the data. A write to 0x014 clears the enable bits that are 1 in the data. A read of 0x010 returns the mask, with source n in bit n.
- R4: A read of 0x008 returns the raw request lines, with source n in bit n, whatever the enable mask holds.
- R5: irq_o is high exactly when some source is both requesting and enabled, and either the stack is empty or that source's level is numerically below the level on top of the stack.
- R6: The winner is the qualifying source with the smallest level value. A tie goes to the lowest source number. A read of the vector register at 0xF00 returns the winner's handler address, which is programmed at 0x100 + 4n.
- R7: A read of the vector register while irq_o is high pushes the winner onto the stack. After that push, sources at the same level or a less urgent level no longer raise irq_o.
- R8: Any write to 0xF00 pops the stack, and the data written has no effect. A write with an empty stack is ignored. A vector read with no qualifying source returns the handler address of the source on top of the stack, or 0 when the stack is empty.
- R9: While a handler is active, a strictly more urgent source raises irq_o and can be pushed on top of the active one. This allows nesting up to 16 levels deep.
- R10: Read data appears on bus_rdata_o one clock after the read is accepted. Reads of unmapped offsets return 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_req_i | input | NUM_SRC | Level request lines, bit n is source n |
| bus_sel_i | input | 1 | Bus access strobe, one cycle per access |
| bus_we_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | 12 | Byte offset of the register |
| bus_wdata_i | input | DATA_W | Write data |
| bus_rdata_o | output | DATA_W | Registered read data |
| irq_o | output | 1 | Interrupt line to the processor |

## Verification
The assertions assume that bus accesses are one-cycle strobes whose address and data are stable at the sampling edge. They also assume that the request lines hold their level across any access whose result depends on them. The bench drives requests and bus signals only on the falling edge, with one access in flight at a time. It changes request levels only between accesses. It reprograms priorities only while no handler is active, so that the levels held on the stack and the bench's own reference model stay consistent.

// File: rtl/pvic_pkg.sv
package pvic_pkg;
   localparam int ADDR_W = 12;

   localparam logic [ADDR_W-1:0] OFF_RAW    = 12'h008;
   localparam logic [ADDR_W-1:0] OFF_EN_SET = 12'h010;
   localparam logic [ADDR_W-1:0] OFF_EN_CLR = 12'h014;
   localparam logic [ADDR_W-1:0] OFF_HAND   = 12'h100;
   localparam logic [ADDR_W-1:0] OFF_PRIO   = 12'h200;
   localparam logic [ADDR_W-1:0] OFF_VEC    = 12'hF00;

   // word slot n of a per-source register page
   function automatic logic [ADDR_W-1:0] slot_addr(input logic [ADDR_W-1:0] base, input int n);
      return base + ADDR_W'(4 * n);
   endfunction
endpackage

// File: rtl/pvic_regs.sv
module pvic_regs #(
   parameter int NUM_SRC = 32,
   parameter int PRIO_W  = 4,
   parameter int DATA_W  = 32
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      wr_i,
   input  logic [pvic_pkg::ADDR_W-1:0] addr_i,
   input  logic [DATA_W-1:0]         wdata_i,
   output logic [NUM_SRC-1:0]        en_o,
   output logic [PRIO_W-1:0]         prio_o [NUM_SRC],
   output logic [DATA_W-1:0]         hand_o [NUM_SRC]
);
   import pvic_pkg::*;

   logic [NUM_SRC-1:0] en_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q <= '0;
      end else if (wr_i && addr_i == OFF_EN_SET) begin
         en_q <= en_q | wdata_i[NUM_SRC-1:0];
      end else if (wr_i && addr_i == OFF_EN_CLR) begin
         en_q <= en_q & ~wdata_i[NUM_SRC-1:0];
      end
   end
   assign en_o = en_q;

   for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
      logic [PRIO_W-1:0] lvl_q;
      logic [DATA_W-1:0] vec_q;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            lvl_q <= '1;
         end else if (wr_i && addr_i == slot_addr(OFF_PRIO, g)) begin
            lvl_q <= wdata_i[PRIO_W-1:0];
         end
      end

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            vec_q <= '0;
         end else if (wr_i && addr_i == slot_addr(OFF_HAND, g)) begin
            vec_q <= wdata_i;
         end
      end

      assign prio_o[g] = lvl_q;
      assign hand_o[g] = vec_q;
   end
endmodule

// File: rtl/pvic_arbiter.sv
module pvic_arbiter #(
   parameter int NUM_SRC = 32,
   parameter int PRIO_W  = 4,
   localparam int IDX_W  = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
   input  logic [NUM_SRC-1:0] req_i,
   input  logic [NUM_SRC-1:0] en_i,
   input  logic [PRIO_W-1:0]  prio_i [NUM_SRC],
   input  logic [PRIO_W-1:0]  top_prio_i,
   input  logic               stk_empty_i,
   output logic               any_o,
   output logic [IDX_W-1:0]   win_idx_o,
   output logic [PRIO_W-1:0]  win_prio_o
);
   logic [NUM_SRC-1:0] elig;

   for (genvar g = 0; g < NUM_SRC; g++) begin : g_elig
      assign elig[g] = req_i[g] & en_i[g] & (stk_empty_i | (prio_i[g] < top_prio_i));
   end

   // scan from the highest number down so ties settle on the lowest number
   always_comb begin
      any_o      = 1'b0;
      win_idx_o  = '0;
      win_prio_o = '1;
      for (int i = NUM_SRC - 1; i >= 0; i--) begin
         if (elig[i] && (!any_o || prio_i[i] <= win_prio_o)) begin
            any_o      = 1'b1;
            win_idx_o  = IDX_W'(i);
            win_prio_o = prio_i[i];
         end
      end
   end
endmodule

// File: rtl/pvic_nest_stack.sv
module pvic_nest_stack #(
   parameter int DEPTH  = 16,
   parameter int PRIO_W = 4,
   parameter int IDX_W  = 5,
   localparam int DW    = $clog2(DEPTH + 1),
   localparam int PW    = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              push_i,
   input  logic [PRIO_W-1:0] push_prio_i,
   input  logic [IDX_W-1:0]  push_idx_i,
   input  logic              pop_i,
   output logic [DW-1:0]     depth_o,
   output logic [PRIO_W-1:0] top_prio_o,
   output logic [IDX_W-1:0]  top_idx_o,
   output logic              empty_o,
   output logic              full_o
);
   logic [PRIO_W-1:0] lvl_q [DEPTH];
   logic [IDX_W-1:0]  src_q [DEPTH];
   logic [DW-1:0]     depth_q;
   logic [PW-1:0]     wptr, tptr;

   assign wptr    = PW'(depth_q);
   assign tptr    = PW'(depth_q - DW'(1));
   assign empty_o = (depth_q == '0);
   assign full_o  = (depth_q == DW'(DEPTH));
   assign depth_o = depth_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         depth_q <= '0;
         for (int k = 0; k < DEPTH; k++) begin
            lvl_q[k] <= '0;
            src_q[k] <= '0;
         end
      end else if (push_i && !full_o) begin
         lvl_q[wptr] <= push_prio_i;
         src_q[wptr] <= push_idx_i;
         depth_q     <= depth_q + DW'(1);
      end else if (pop_i && !empty_o) begin
         depth_q <= depth_q - DW'(1);
      end
   end

   assign top_prio_o = empty_o ? '1 : lvl_q[tptr];
   assign top_idx_o  = empty_o ? '0 : src_q[tptr];
endmodule

// File: rtl/prio_vector_irq_ctrl.sv
module prio_vector_irq_ctrl #(
   parameter int NUM_SRC   = 32,
   parameter int PRIO_W    = 4,
   parameter int DATA_W    = 32,
   parameter int STK_DEPTH = 2 ** PRIO_W,
   localparam int IDX_W    = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1,
   localparam int DW       = $clog2(STK_DEPTH + 1)
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic [NUM_SRC-1:0]          irq_req_i,
   input  logic                        bus_sel_i,
   input  logic                        bus_we_i,
   input  logic [pvic_pkg::ADDR_W-1:0] bus_addr_i,
   input  logic [DATA_W-1:0]           bus_wdata_i,
   output logic [DATA_W-1:0]           bus_rdata_o,
   output logic                        irq_o
);
   import pvic_pkg::*;

   if (NUM_SRC < 1 || NUM_SRC > 64 || NUM_SRC > DATA_W) begin : g_bad_src
      $error("NUM_SRC must be 1..64 and fit in DATA_W");
   end
   if (PRIO_W < 1 || PRIO_W >= DATA_W || PRIO_W > 8) begin : g_bad_prio
      $error("PRIO_W must be 1..8 and below DATA_W");
   end
   if (STK_DEPTH < 1 || STK_DEPTH > 2 ** PRIO_W) begin : g_bad_depth
      $error("STK_DEPTH must be 1..2**PRIO_W");
   end

   logic                wr, rd, vec_rd, push, pop;
   logic [NUM_SRC-1:0]  en_mask;
   logic [PRIO_W-1:0]   prio_q [NUM_SRC];
   logic [DATA_W-1:0]   hand_q [NUM_SRC];
   logic                any_elig, stk_empty, stk_full;
   logic [IDX_W-1:0]    win_idx, top_idx;
   logic [PRIO_W-1:0]   push_prio, top_prio;
   logic [DW-1:0]       depth;
   logic [DATA_W-1:0]   vec_val, rd_mux;

   assign wr     = bus_sel_i & bus_we_i;
   assign rd     = bus_sel_i & ~bus_we_i;
   assign vec_rd = rd & (bus_addr_i == OFF_VEC);
   assign push   = vec_rd & any_elig & ~stk_full;
   assign pop    = wr & (bus_addr_i == OFF_VEC);

   pvic_regs #(.NUM_SRC(NUM_SRC), .PRIO_W(PRIO_W), .DATA_W(DATA_W)) u_regs (
      .clk(clk), .rst_n(rst_n), .wr_i(wr), .addr_i(bus_addr_i), .wdata_i(bus_wdata_i),
      .en_o(en_mask), .prio_o(prio_q), .hand_o(hand_q)
   );

   pvic_arbiter #(.NUM_SRC(NUM_SRC), .PRIO_W(PRIO_W)) u_arb (
      .req_i(irq_req_i), .en_i(en_mask), .prio_i(prio_q), .top_prio_i(top_prio),
      .stk_empty_i(stk_empty), .any_o(any_elig), .win_idx_o(win_idx), .win_prio_o(push_prio)
   );

   pvic_nest_stack #(.DEPTH(STK_DEPTH), .PRIO_W(PRIO_W), .IDX_W(IDX_W)) u_stk (
      .clk(clk), .rst_n(rst_n), .push_i(push), .push_prio_i(push_prio), .push_idx_i(win_idx),
      .pop_i(pop), .depth_o(depth), .top_prio_o(top_prio), .top_idx_o(top_idx),
      .empty_o(stk_empty), .full_o(stk_full)
   );

   assign irq_o = any_elig;

   always_comb begin
      if (push)           vec_val = hand_q[win_idx];
      else if (stk_empty) vec_val = '0;
      else                vec_val = hand_q[top_idx];
   end

   always_comb begin
      rd_mux = '0;
      if (bus_addr_i == OFF_RAW)    rd_mux = DATA_W'(irq_req_i);
      if (bus_addr_i == OFF_EN_SET) rd_mux = DATA_W'(en_mask);
      if (bus_addr_i == OFF_VEC)    rd_mux = vec_val;
      for (int i = 0; i < NUM_SRC; i++) begin
         if (bus_addr_i == slot_addr(OFF_PRIO, i)) rd_mux = DATA_W'(prio_q[i]);
         if (bus_addr_i == slot_addr(OFF_HAND, i)) rd_mux = hand_q[i];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  bus_rdata_o <= '0;
      else if (rd) bus_rdata_o <= rd_mux;
   end
endmodule

// File: rtl/pvic_checker.sv
module pvic_checker #(
   parameter int NUM_SRC = 32,
   parameter int PRIO_W  = 4,
   parameter int DATA_W  = 32,
   parameter int DW      = 5
) (
   input logic                        clk,
   input logic                        rst_n,
   input logic                        bus_sel_i,
   input logic                        bus_we_i,
   input logic [pvic_pkg::ADDR_W-1:0] bus_addr_i,
   input logic [DATA_W-1:0]           bus_rdata_o,
   input logic                        irq_o,
   input logic [NUM_SRC-1:0]          irq_req_i,
   input logic [NUM_SRC-1:0]          en_mask,
   input logic [DW-1:0]               depth,
   input logic                        push,
   input logic                        stk_empty,
   input logic [PRIO_W-1:0]           push_prio,
   input logic [PRIO_W-1:0]           top_prio
);
   import pvic_pkg::*;

   logic prio_rd;
   assign prio_rd = bus_sel_i && !bus_we_i && bus_addr_i[1:0] == 2'b00 &&
                    bus_addr_i >= OFF_PRIO && bus_addr_i < slot_addr(OFF_PRIO, NUM_SRC);

   assert_irq_needs_src_R5: assert property (@(posedge clk) disable iff (!rst_n)
      irq_o |-> (|(irq_req_i & en_mask)));

   assert_idle_stack_irq_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (stk_empty && (|(irq_req_i & en_mask))) |-> irq_o);

   assert_prio_upper_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
      prio_rd |=> (bus_rdata_o[DATA_W-1:PRIO_W] == '0));

   assert_push_grows_R7: assert property (@(posedge clk) disable iff (!rst_n)
      push |=> (depth == $past(depth) + DW'(1)));

   assert_ack_pops_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_sel_i && bus_we_i && bus_addr_i == OFF_VEC && !stk_empty) |=>
      (depth == $past(depth) - DW'(1)));

   assert_nest_strict_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (push && !stk_empty) |-> (push_prio < top_prio));
endmodule

bind prio_vector_irq_ctrl pvic_checker #(
   .NUM_SRC(NUM_SRC), .PRIO_W(PRIO_W), .DATA_W(DATA_W), .DW(DW)
) u_chk (
   .clk(clk), .rst_n(rst_n), .bus_sel_i(bus_sel_i), .bus_we_i(bus_we_i),
   .bus_addr_i(bus_addr_i), .bus_rdata_o(bus_rdata_o), .irq_o(irq_o),
   .irq_req_i(irq_req_i), .en_mask(en_mask), .depth(depth), .push(push),
   .stk_empty(stk_empty), .push_prio(push_prio), .top_prio(top_prio)
);

// File: tb/prio_vector_irq_ctrl_test.sv
`timescale 1ns/1ps
module prio_vector_irq_ctrl_test;
   localparam int N = 32;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [N-1:0] req = '0;
   logic        sel = 1'b0, we = 1'b0;
   logic [11:0] addr = '0;
   logic [31:0] wdata = '0;
   logic [31:0] rdata;
   logic        irq;

   int n_cmp = 0, n_bad = 0;
   bit done = 0;

   // reference model
   logic [3:0]  prio_m [N];
   logic [31:0] hand_m [N];
   logic [N-1:0] en_m;
   int          stk_src [16];
   logic [3:0]  stk_lvl [16];
   int          stk_n;

   prio_vector_irq_ctrl uut (
      .clk(clk), .rst_n(rst_n), .irq_req_i(req), .bus_sel_i(sel), .bus_we_i(we),
      .bus_addr_i(addr), .bus_wdata_i(wdata), .bus_rdata_o(rdata), .irq_o(irq)
   );

   always #2.5 clk = ~clk;

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: got %h expected %h", tag, act, exp);
      end
   endtask

   function automatic bit elig(input int i);
      return req[i] && en_m[i] && (stk_n == 0 || prio_m[i] < stk_lvl[(stk_n > 0) ? stk_n - 1 : 0]);
   endfunction

   function automatic int pick();
      int w = -1;
      for (int i = 0; i < N; i++)
         if (elig(i) && (w < 0 || prio_m[i] < prio_m[w])) w = i;
      return w;
   endfunction

   task automatic bus_write(input logic [11:0] a, input logic [31:0] d);
      @(negedge clk);
      sel = 1; we = 1; addr = a; wdata = d;
      @(negedge clk);
      sel = 0; we = 0;
      if (a == 12'h010) en_m = en_m | d;
      else if (a == 12'h014) en_m = en_m & ~d;
      else if (a == 12'hF00) begin if (stk_n > 0) stk_n--; end
      else if (a >= 12'h200 && a < 12'h280 && a[1:0] == 0) prio_m[(a - 12'h200) >> 2] = d[3:0];
      else if (a >= 12'h100 && a < 12'h180 && a[1:0] == 0) hand_m[(a - 12'h100) >> 2] = d;
   endtask

   task automatic bus_read(input logic [11:0] a, output logic [31:0] d);
      @(negedge clk);
      sel = 1; we = 0; addr = a;
      @(negedge clk);
      sel = 0;
      d = rdata;
   endtask

   function automatic logic [31:0] vec_expect_and_update();
      int w = pick();
      if (w >= 0 && stk_n < 16) begin
         stk_src[stk_n] = w; stk_lvl[stk_n] = prio_m[w]; stk_n++;
         return hand_m[w];
      end
      return (stk_n == 0) ? 32'h0 : hand_m[stk_src[stk_n - 1]];
   endfunction

   task automatic vec_read(input string tag);
      logic [31:0] d, e;
      e = vec_expect_and_update();
      bus_read(12'hF00, d);
      check(tag, d, e);
   endtask

   task automatic check_irq(input string tag);
      #0.5;
      check(tag, {31'h0, irq}, {31'h0, pick() >= 0});
   endtask

   task automatic set_req(input logic [N-1:0] v);
      @(negedge clk);
      req = v;
   endtask

   initial begin
      #1_000_000;
      if (!done) begin
         n_cmp++; n_bad++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   initial begin
      logic [31:0] d;
      void'($urandom(32'd20240611));
      for (int i = 0; i < N; i++) begin prio_m[i] = 4'hF; hand_m[i] = '0; end
      en_m = '0; stk_n = 0;
      repeat (3) @(negedge clk);
      rst_n = 1;

      // R1 reset state
      check_irq("R1 irq after reset");
      bus_read(12'h200, d); check("R1 prio0 reset", d, 32'hF);
      bus_read(12'h27C, d); check("R1 prio31 reset", d, 32'hF);
      bus_read(12'h010, d); check("R1 enable reset", d, 32'h0);
      bus_read(12'hF00, d); check("R1 vector reset", d, 32'h0);

      // R2 upper bits ignored
      bus_write(12'h214, 32'hFFFF_FFF3);
      bus_read(12'h214, d); check("R2 prio5 readback", d, 32'h3);

      // R3 set/clear enable
      bus_write(12'h010, 32'h0000_00F0);
      bus_write(12'h010, 32'h0000_0001);
      bus_write(12'h014, 32'h0000_0010);
      bus_read(12'h010, d); check("R3 enable mask", d, 32'h0000_00E1);
      bus_write(12'h014, 32'hFFFF_FFFF);

      // R4 raw status ignores enable
      set_req(32'hA5C3_0F18);
      bus_read(12'h008, d); check("R4 raw status", d, 32'hA5C3_0F18);
      check_irq("R5 none enabled");

      // R10 unmapped
      bus_read(12'h040, d); check("R10 unmapped 0x040", d, 32'h0);
      bus_read(12'hF04, d); check("R10 unmapped 0xF04", d, 32'h0);
      set_req('0);

      // directed nesting scenario
      for (int i = 0; i < N; i++) bus_write(12'(12'h100 + 4 * i), 32'hA000_0000 + 32'(i * 16));
      bus_write(12'h20C, 32'h2);   // src3 level 2
      bus_write(12'h21C, 32'h2);   // src7 level 2
      bus_write(12'h224, 32'h1);   // src9 level 1
      bus_write(12'h230, 32'h2);   // src12 level 2
      bus_write(12'h010, (32'h1 << 3) | (32'h1 << 7) | (32'h1 << 9) | (32'h1 << 12));
      set_req((32'h1 << 3) | (32'h1 << 7));
      check_irq("R5 pending enabled");
      bus_read(12'hF00, d); check("R6 tie lowest number", d, 32'hA000_0030);
      stk_src[0] = 3; stk_lvl[0] = 2; stk_n = 1;
      check_irq("R7 same level masked");
      set_req((32'h1 << 3) | (32'h1 << 7) | (32'h1 << 12));
      check_irq("R7 same level masked 2");
      set_req((32'h1 << 3) | (32'h1 << 7) | (32'h1 << 9) | (32'h1 << 12));
      check_irq("R9 preempt raises irq");
      check({31'h0, irq}, 32'h1, 32'h1);
      vec_read("R9 nested vector");
      check_irq("R7 after nested push");
      bus_write(12'hF00, 32'h1234_5678);
      check_irq("R8 pop restores threshold");
      set_req((32'h1 << 3) | (32'h1 << 7) | (32'h1 << 12));
      check_irq("R8 outer level masks");
      bus_read(12'hF00, d); check("R8 outer handler", d, 32'hA000_0030);
      bus_write(12'hF00, 32'h0);
      check_irq("R8 empty stack irq");
      set_req('0);
      bus_read(12'hF00, d); check("R8 idle vector zero", d, 32'h0);
      bus_write(12'hF00, 32'hFFFF_FFFF);
      set_req(32'h1 << 7);
      check_irq("R8 empty ack ignored");
      vec_read("R6 single source");
      bus_write(12'hF00, 32'h0);
      set_req('0);

      // random phase
      for (int i = 0; i < N; i++) begin
         bus_write(12'(12'h200 + 4 * i), $urandom);
         bus_write(12'(12'h100 + 4 * i), $urandom);
      end
      bus_write(12'h014, 32'hFFFF_FFFF);
      bus_write(12'h010, $urandom);
      for (int it = 0; it < 400; it++) begin
         int op = $urandom % 6;
         case (op)
            0: set_req($urandom & $urandom & $urandom);
            1, 2: vec_read("R6 random vector");
            3: bus_write(12'hF00, $urandom);
            4: begin
               int s = $urandom % N;
               if (stk_n == 0) bus_write(12'(12'h200 + 4 * s), $urandom);
               bus_read(12'(12'h200 + 4 * s), d); check("R2 random prio", d, {28'h0, prio_m[s]});
            end
            default: begin
               bus_read(12'h008, d); check("R4 random raw", d, req);
            end
         endcase
         check_irq("R5 random irq");
      end

      done = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule